// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor load/store port and a slower memory. It holds copies of memory blocks in a two-way set-associative array. A read that hits returns one 64-bit word in the same cycle as the request. A write that hits changes only the cached copy and marks the line dirty. On a miss, the cache first writes the chosen victim line back to memory if that line is dirty, then fetches the requested block. After the fetch it completes the access from the array, so a write miss allocates the line before the write takes effect.

The processor presents an address of an 8-byte word, a write flag and write data, and holds them stable until `cpu_ack` rises. With the default sizes the cache stores 64 KiB as 512 sets of two 64-byte lines. The memory side moves one whole line per burst. The cache holds `mem_req` high with a fixed line address and direction, and each cycle in which the memory raises `mem_ack` transfers one 64-bit beat.

Top module: `cwb2_cache`

## Requirements
- R1: After reset every line is invalid and no memory burst is pending, so the first access to any set is a miss.
- R2: When the request is present, the cache is idle, and a valid line in the addressed set holds the address tag, `cpu_ack` is high in that same cycle. `cpu_rdata` then carries the word of that line that the three low bits of `cpu_waddr` select.
- R3: A write hit stores `cpu_wdata` into the selected word only, marks the line dirty and causes no memory traffic.
- R4: A refill is one burst with `mem_we` low that carries eight beats. Beat k carries word k, in order from word 0 to word 7. `mem_addr` and `mem_we` stay constant while a beat is waiting for `mem_ack`.
- R5: A write miss first fills the line from memory and then merges the write word. The other seven words keep their memory values.
- R6: A dirty victim is written to memory as an eight-beat burst with `mem_we` high, words 0 to 7, before the refill begins. A clean victim produces no write burst.
- R7: The victim is an invalid way when one exists, trying way 0 first. Otherwise the victim is the way that was not used most recently. Every hit and every fill counts as a use of that way.
- R8: `cpu_ack` never rises while a memory burst is active. A missed request is stalled until the fill completes and the access re-executes as a hit.
- R9: `cpu_waddr` splits, from the top, into a 29-bit tag [40:12], a 9-bit set index [11:3] and a 3-bit word select [2:0]. `mem_addr` is the line address {tag, set}, which is the tag of the victim during a write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, held until acknowledged |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_waddr | input | 41 | 8-byte word address {tag, set, word} |
| cpu_wdata | input | 64 | Write data |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_rdata | output | 64 | Read data, valid with cpu_ack |
| mem_req | output | 1 | Burst active |
| mem_we | output | 1 | 1 = write-back burst, 0 = refill burst |
| mem_addr | output | 38 | Line address {tag, set} |
| mem_wdata | output | 64 | Write-back beat data |
| mem_ack | input | 1 | Beat transferred this cycle |
| mem_rdata | input | 64 | Refill beat data |

## Verification
The bench drives four tags into four sets, so that sets overflow and force evictions. It mixes reads and writes at random, and the memory acknowledges beats at random. A directed opening walks one set through the main cases in turn: a cold miss, a hit, a write hit, a fill into the second invalid way, a clean eviction that the LRU state decides, a dirty eviction, and a write miss followed by reads of the merged word and a neighbouring word. For each access the bench predicts the hit or miss, the number of write-back and fill beats, the line address and the returned data. A hit that arrives late or is missing shows up as a wrong replacement choice. Lost write-backs show up as stale data and as a mismatch in the memory image. A merge in the wrong word shows up in the read after the write miss.

// File: rtl/cwb2_pkg.sv
package cwb2_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2,
      ST_DONE  = 2'd3
   } miss_state_e;
endpackage

// File: rtl/cwb2_tag_store.sv
module cwb2_tag_store #(
   parameter int SETS  = 512,
   parameter int TAG_W = 29,
   localparam int SET_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] lk_set,
   input  logic [TAG_W-1:0] lk_tag,
   output logic [1:0]       hit_way,
   output logic             vic_way,
   output logic             vic_dirty,
   output logic [TAG_W-1:0] vic_tag,
   input  logic             touch_en,
   input  logic             touch_way,
   input  logic             dirty_en,
   input  logic             dirty_way,
   input  logic             inst_en,
   input  logic             inst_way,
   input  logic [TAG_W-1:0] inst_tag
);
   logic [1:0]       way_vld;
   logic [1:0]       way_drt;
   logic [TAG_W-1:0] way_tag [2];
   logic [SETS-1:0]  lru_q;   // way to evict next

   for (genvar w = 0; w < 2; w++) begin : g_way
      localparam logic WID = 1'(w);
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  vld_q;
      logic [SETS-1:0]  drt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
         end else if (inst_en && inst_way == WID) begin
            vld_q[lk_set] <= 1'b1;
            drt_q[lk_set] <= 1'b0;
         end else if (dirty_en && dirty_way == WID) begin
            drt_q[lk_set] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (inst_en && inst_way == WID) tag_q[lk_set] <= inst_tag;
      end

      assign way_vld[w] = vld_q[lk_set];
      assign way_drt[w] = drt_q[lk_set];
      assign way_tag[w] = tag_q[lk_set];
      assign hit_way[w] = vld_q[lk_set] && (tag_q[lk_set] == lk_tag);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        lru_q <= '0;
      else if (touch_en) lru_q[lk_set] <= ~touch_way;
   end

   always_comb begin
      if (!way_vld[0])      vic_way = 1'b0;
      else if (!way_vld[1]) vic_way = 1'b1;
      else                  vic_way = lru_q[lk_set];
      vic_dirty = way_vld[vic_way] && way_drt[vic_way];
      vic_tag   = way_tag[vic_way];
   end
endmodule

// File: rtl/cwb2_line_store.sv
module cwb2_line_store #(
   parameter int SETS   = 512,
   parameter int WORD_W = 64,
   parameter int BEATS  = 8,
   localparam int SET_W  = $clog2(SETS),
   localparam int BEAT_W = $clog2(BEATS),
   localparam int LINE_W = WORD_W * BEATS
) (
   input  logic                  clk,
   input  logic [SET_W-1:0]      set_idx,
   input  logic [BEAT_W-1:0]     rd_word,
   output logic [1:0][WORD_W-1:0] rd_data,
   input  logic                  wr_en,
   input  logic                  wr_way,
   input  logic [BEAT_W-1:0]     wr_word,
   input  logic [WORD_W-1:0]     wr_data
);
   for (genvar w = 0; w < 2; w++) begin : g_way
      localparam logic WID = 1'(w);
      logic [LINE_W-1:0] line_q [SETS];

      always_ff @(posedge clk) begin
         if (wr_en && wr_way == WID)
            line_q[set_idx][wr_word*WORD_W +: WORD_W] <= wr_data;
      end

      assign rd_data[w] = line_q[set_idx][rd_word*WORD_W +: WORD_W];
   end
endmodule

// File: rtl/cwb2_miss_ctrl.sv
module cwb2_miss_ctrl
   import cwb2_pkg::*;
#(
   parameter int TAG_W = 29,
   parameter int BEATS = 8,
   localparam int BEAT_W = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              lookup_miss,
   input  logic              vic_way,
   input  logic              vic_dirty,
   input  logic [TAG_W-1:0]  vic_tag,
   input  logic              mem_ack,
   output logic              in_idle,
   output logic              busy_wb,
   output logic              busy_fill,
   output logic              fill_wr,
   output logic              fill_done,
   output logic              sel_way,
   output logic [TAG_W-1:0]  wb_tag,
   output logic [BEAT_W-1:0] beat
);
   miss_state_e st_q;
   logic        beat_last;

   assign beat_last = (beat == BEAT_W'(BEATS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         beat    <= '0;
         sel_way <= 1'b0;
         wb_tag  <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (cpu_req && lookup_miss) begin
               sel_way <= vic_way;
               wb_tag  <= vic_tag;
               beat    <= '0;
               st_q    <= vic_dirty ? ST_WBACK : ST_FILL;
            end
            ST_WBACK: if (mem_ack) begin
               beat <= beat + 1'b1;
               if (beat_last) st_q <= ST_FILL;
            end
            ST_FILL: if (mem_ack) begin
               beat <= beat + 1'b1;
               if (beat_last) st_q <= ST_DONE;
            end
            ST_DONE: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign in_idle   = (st_q == ST_IDLE);
   assign busy_wb   = (st_q == ST_WBACK);
   assign busy_fill = (st_q == ST_FILL);
   assign fill_wr   = busy_fill && mem_ack;
   assign fill_done = fill_wr && beat_last;
endmodule

// File: rtl/cwb2_cache.sv
module cwb2_cache #(
   parameter int ADDR_W     = 44,
   parameter int SETS       = 512,
   parameter int LINE_BYTES = 64,
   parameter int WORD_W     = 64,
   localparam int BYTE_W = $clog2(WORD_W / 8),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SET_W  = $clog2(SETS),
   localparam int BEATS  = LINE_BYTES / (WORD_W / 8),
   localparam int BEAT_W = $clog2(BEATS),
   localparam int TAG_W  = ADDR_W - SET_W - OFF_W,
   localparam int WA_W   = ADDR_W - BYTE_W,
   localparam int BLK_W  = TAG_W + SET_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [WA_W-1:0]   cpu_waddr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic              cpu_ack,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [BLK_W-1:0]  mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [WORD_W-1:0] mem_rdata
);
   if ((1 << SET_W) != SETS) begin : g_bad_sets
      $error("SETS must be a power of two");
   end
   if ((1 << OFF_W) != LINE_BYTES || BEATS < 2 || (1 << BEAT_W) != BEATS) begin : g_bad_line
      $error("LINE_BYTES must be a power-of-two multiple of the word size");
   end
   if (WORD_W % 8 != 0 || (8 << BYTE_W) != WORD_W) begin : g_bad_word
      $error("WORD_W must be a power-of-two number of bytes");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for the set and offset fields");
   end

   logic [TAG_W-1:0]  a_tag;
   logic [SET_W-1:0]  a_set;
   logic [BEAT_W-1:0] a_word;

   assign a_word = cpu_waddr[BEAT_W-1:0];
   assign a_set  = cpu_waddr[BEAT_W +: SET_W];
   assign a_tag  = cpu_waddr[WA_W-1 -: TAG_W];

   logic [1:0]        hit_way;
   logic              hit, hit_sel;
   logic              vic_way, vic_dirty;
   logic [TAG_W-1:0]  vic_tag, wb_tag;
   logic              in_idle, busy_wb, busy_fill, fill_wr, fill_done, sel_way;
   logic [BEAT_W-1:0] beat;
   logic              cpu_wr;
   logic [1:0][WORD_W-1:0] rd_data;

   assign hit     = |hit_way;
   assign hit_sel = hit_way[1];
   assign cpu_ack = in_idle && cpu_req && hit;
   assign cpu_wr  = cpu_ack && cpu_we;

   cwb2_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_set    (a_set),
      .lk_tag    (a_tag),
      .hit_way   (hit_way),
      .vic_way   (vic_way),
      .vic_dirty (vic_dirty),
      .vic_tag   (vic_tag),
      .touch_en  (cpu_ack || fill_done),
      .touch_way (fill_done ? sel_way : hit_sel),
      .dirty_en  (cpu_wr),
      .dirty_way (hit_sel),
      .inst_en   (fill_done),
      .inst_way  (sel_way),
      .inst_tag  (a_tag)
   );

   cwb2_line_store #(.SETS(SETS), .WORD_W(WORD_W), .BEATS(BEATS)) u_lines (
      .clk     (clk),
      .set_idx (a_set),
      .rd_word (busy_wb ? beat : a_word),
      .rd_data (rd_data),
      .wr_en   (cpu_wr || fill_wr),
      .wr_way  (fill_wr ? sel_way : hit_sel),
      .wr_word (fill_wr ? beat : a_word),
      .wr_data (fill_wr ? mem_rdata : cpu_wdata)
   );

   cwb2_miss_ctrl #(.TAG_W(TAG_W), .BEATS(BEATS)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .cpu_req     (cpu_req),
      .lookup_miss (!hit),
      .vic_way     (vic_way),
      .vic_dirty   (vic_dirty),
      .vic_tag     (vic_tag),
      .mem_ack     (mem_ack),
      .in_idle     (in_idle),
      .busy_wb     (busy_wb),
      .busy_fill   (busy_fill),
      .fill_wr     (fill_wr),
      .fill_done   (fill_done),
      .sel_way     (sel_way),
      .wb_tag      (wb_tag),
      .beat        (beat)
   );

   assign cpu_rdata = rd_data[hit_sel];
   assign mem_wdata = rd_data[sel_way];
   assign mem_req   = busy_wb || busy_fill;
   assign mem_we    = busy_wb;
   assign mem_addr  = {(busy_wb ? wb_tag : a_tag), a_set};
endmodule

// File: rtl/cwb2_cache_chk.sv
module cwb2_cache_chk #(
   parameter int BLK_W = 38
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req,
   input logic             cpu_ack,
   input logic             mem_req,
   input logic             mem_we,
   input logic             mem_ack,
   input logic [BLK_W-1:0] mem_addr,
   input logic [1:0]       hit_way
);
   assert_single_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_way));

   assert_burst_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   assert_wb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |=> !(mem_req && mem_we));

   assert_no_ack_in_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(cpu_ack && mem_req));

   assert_ack_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ack |-> cpu_req);

   assert_burst_from_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(cpu_req && !cpu_ack));
endmodule

bind cwb2_cache cwb2_cache_chk #(.BLK_W(BLK_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_ack  (cpu_ack),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_ack  (mem_ack),
   .mem_addr (mem_addr),
   .hit_way  (hit_way)
);

// File: tb/cwb2_cache_bench.sv
module cwb2_cache_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WA_W  = 41;
   localparam int BLK_W = 38;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cpu_req = 1'b0;
   logic              cpu_we = 1'b0;
   logic [WA_W-1:0]   cpu_waddr = '0;
   logic [63:0]       cpu_wdata = '0;
   logic              cpu_ack;
   logic [63:0]       cpu_rdata;
   logic              mem_req;
   logic              mem_we;
   logic [BLK_W-1:0]  mem_addr;
   logic [63:0]       mem_wdata;
   logic              mem_ack = 1'b0;
   logic [63:0]       mem_rdata = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cwb2_cache u_cwb2_cache (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
      .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata)
   );

   int n_checks = 0;
   int n_fail = 0;
   int fill_beats = 0;
   int wb_beats = 0;
   int last_fill_blk = -1;
   int last_wb_blk = -1;
   logic [63:0] lmem [128];   // lower memory image, index {tag,set,word}
   logic [63:0] refm [128];   // value the processor must observe

   // cache model
   int  m_tag [4][2];
   bit  m_vld [4][2];
   bit  m_drt [4][2];
   bit  m_lru [4];

   function automatic logic [63:0] seed_word(int i);
      return {32'hC0DE0000 | 32'(i), 32'(i) * 32'h9E3779B9};
   endfunction

   task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // lower memory: random beat acknowledges
   logic [2:0] mbeat = '0;
   always @(negedge clk) begin
      if (!mem_req) begin
         mem_ack = 1'b0;
         mbeat   = '0;
      end else begin
         mem_ack = ($urandom % 4) != 0;
         if (mem_ack) begin
            int tg, st, idx;
            tg = int'(mem_addr[37:9]);
            st = int'(mem_addr[8:0]);
            idx = ((tg & 3) << 5) | ((st & 3) << 3) | int'(mbeat);
            if (tg > 3 || st > 3) check(1'b0, "R9 line address", 64'(mem_addr), 64'(0));
            if (mem_we) begin
               lmem[idx] = mem_wdata;
               wb_beats++;
               last_wb_blk = tg * 16 + st;
            end else begin
               mem_rdata = lmem[idx];
               fill_beats++;
               last_fill_blk = tg * 16 + st;
            end
            mbeat = mbeat + 3'd1;
         end
      end
   end

   task automatic access(bit we, int tg, int st, int wd, logic [63:0] wv,
                         output logic [63:0] rv, output int wc);
      @(negedge clk);
      cpu_req   = 1'b1;
      cpu_we    = we;
      cpu_waddr = {29'(tg), 9'(st), 3'(wd)};
      cpu_wdata = wv;
      wc = 0;
      #1;
      while (!cpu_ack && wc < 400) begin
         @(negedge clk);
         #1;
         wc++;
      end
      rv = cpu_rdata;
      @(posedge clk);
      #1;
      cpu_req = 1'b0;
   endtask

   task automatic step(bit we, int tg, int st, int wd, logic [63:0] wv, string rlab);
      int hw = -1, vw = 0, way, wc, f0, w0, vtag;
      bit ex_hit, ex_wb = 0;
      logic [63:0] rv;
      int idx = (tg << 5) | (st << 3) | wd;
      for (int w = 0; w < 2; w++)
         if (m_vld[st][w] && m_tag[st][w] == tg) hw = w;
      ex_hit = (hw >= 0);
      if (!ex_hit) begin
         vw = !m_vld[st][0] ? 0 : (!m_vld[st][1] ? 1 : int'(m_lru[st]));
         ex_wb = m_vld[st][vw] && m_drt[st][vw];
      end
      vtag = m_tag[st][vw];
      f0 = fill_beats;
      w0 = wb_beats;
      access(we, tg, st, wd, wv, rv, wc);
      // R7 / R2: hit decided by replacement history, hit answered in same cycle
      check((wc == 0) == ex_hit, ex_hit ? "R2 hit same cycle" : "R7 miss expected",
            64'(wc), 64'(ex_hit ? 0 : 1));
      if (!ex_hit) begin
         check(wc >= 8, "R8 stall through fill", 64'(wc), 64'(8));
         check(last_fill_blk == tg * 16 + st, "R9 fill line address",
               64'(last_fill_blk), 64'(tg * 16 + st));
      end
      check(fill_beats - f0 == (ex_hit ? 0 : 8), "R4 fill beats",
            64'(fill_beats - f0), 64'(ex_hit ? 0 : 8));
      check(wb_beats - w0 == (ex_wb ? 8 : 0), (we && ex_hit) ? "R3 no traffic on write hit" : "R6 write-back beats",
            64'(wb_beats - w0), 64'(ex_wb ? 8 : 0));
      if (ex_wb) begin
         check(last_wb_blk == vtag * 16 + st, "R6 victim address",
               64'(last_wb_blk), 64'(vtag * 16 + st));
         for (int k = 0; k < 8; k++) begin
            int vi = (vtag << 5) | (st << 3) | k;
            check(lmem[vi] == refm[vi], "R6 written-back data", lmem[vi], refm[vi]);
         end
      end
      if (!we) check(rv === refm[idx], rlab, rv, refm[idx]);
      if (ex_hit) way = hw;
      else begin
         way = vw;
         m_tag[st][way] = tg;
         m_vld[st][way] = 1'b1;
         m_drt[st][way] = 1'b0;
      end
      if (we) begin
         m_drt[st][way] = 1'b1;
         refm[idx] = wv;
      end
      m_lru[st] = (way == 0);
   endtask

   task automatic summary_and_end();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary_and_end();
   end

   initial begin
      void'($urandom(32'd2718));
      for (int i = 0; i < 128; i++) begin
         lmem[i] = seed_word(i);
         refm[i] = seed_word(i);
      end
      for (int s = 0; s < 4; s++) begin
         m_lru[s] = 1'b0;
         for (int w = 0; w < 2; w++) begin
            m_vld[s][w] = 1'b0;
            m_drt[s][w] = 1'b0;
            m_tag[s][w] = 0;
         end
      end
      repeat (3) @(negedge clk);
      check(cpu_ack == 1'b0 && mem_req == 1'b0, "R1 reset outputs",
            {62'd0, cpu_ack, mem_req}, 64'd0);
      rst_n = 1'b1;

      // directed walk through one set
      step(0, 0, 0, 3, '0, "R1 cold miss data");
      step(0, 0, 0, 0, '0, "R2 hit data");
      step(1, 0, 0, 5, 64'hA5A5_0000_1111_2222, "R3");
      step(0, 0, 0, 5, '0, "R3 write hit readback");
      step(0, 1, 0, 2, '0, "R7 invalid way fill");
      step(0, 0, 0, 5, '0, "R7 first line kept");
      step(0, 2, 0, 1, '0, "R7 clean LRU eviction");
      step(0, 3, 0, 0, '0, "R6 dirty eviction");
      step(0, 0, 0, 5, '0, "R6 reread written-back word");
      step(1, 1, 1, 2, 64'h0123_4567_89AB_CDEF, "R5");
      step(0, 1, 1, 2, '0, "R5 merged word");
      step(0, 1, 1, 3, '0, "R5 neighbour word from memory");
      step(0, 2, 1, 7, '0, "R9 set 1 second way");
      step(0, 2, 2, 7, '0, "R9 same tag other set");

      // constrained random traffic over four tags and four sets
      for (int n = 0; n < 2500; n++) begin
         bit we = ($urandom % 3) == 0;
         step(we, int'($urandom % 4), int'($urandom % 4), int'($urandom % 8),
              {$urandom, $urandom}, "R2 random read data");
      end
      repeat (4) @(negedge clk);
      summary_and_end();
   end
endmodule